// File: doc/BRIEF.md
# Masked Receiver Error Aggregator

This block gathers seven receiver error conditions and passes each one through a host-written enable mask. A mask bit of 1 enables its error and a bit of 0 suppresses it. Each enabled error is latched into a sticky error register that the host can read. The OR of the latched bits forms an aggregate error output. Each enabled error also raises a one-cycle event toward the interrupt logic.

The block also gives the audio path one decision per sample. On every sample boundary strobe it looks at the enabled errors seen since the previous boundary and tells the audio path what to do with the sample. The audio path repeats the last good sample, substitutes zero, or passes the sample unchanged, as the hold-mode select chooses. The two CRC error classes are excluded from this decision. They reach the register, the aggregate output and the event like the other classes, but they never alter audio.

The error strobe and register bit positions are fixed: bit 0 parity, bit 1 biphase, bit 2 confidence, bit 3 validity, bit 4 lock loss, bit 5 channel-status CRC, bit 6 subcode CRC, and bit 7 always 0. The asynchronous active-low reset is released synchronously through two internal flops. The block therefore accepts stimulus from the third rising edge after `rst_n` goes high.

Top module: `rx_error_filter`

## Requirements
- R1: While in reset and after reset, `err_reg`, `agg_err`, `err_event`, `sample_hold` and `sample_zero` are 0, and the enable mask is 00h, so every error is suppressed.
- R2: When `err_strobe[i]` is high in a cycle and mask bit i is 1, `err_reg[i]` is 1 from the next rising edge onward. `err_reg[7]` always reads 0.
- R3: An error whose mask bit is 0 leaves `err_reg`, `agg_err` and `err_event` unchanged and has no effect on `sample_hold` or `sample_zero`.
- R4: `err_reg` bits are sticky. A cycle with `err_rd` high clears them at the next edge, except for bits set by an enabled strobe in that same cycle, which stay 1.
- R5: `agg_err` is 1 exactly when any `err_reg` bit is 1.
- R6: `err_event` is high for the cycle after every cycle that has at least one enabled error strobe, and is low otherwise.
- R7: On a cycle with `sample_tick` high, the sample decision is taken. It counts enabled non-CRC errors (bits 0 to 4) seen since the previous tick, including the tick cycle itself. The result appears on `sample_hold`/`sample_zero` after that edge and is held until the next tick. A tick with no such error drives both outputs low.
- R8: Errors on bits 5 and 6 never raise `sample_hold` or `sample_zero`, even when enabled.
- R9: `hold_mode`, sampled at the tick, selects the action taken on an affected sample. 00 repeats the sample (`sample_hold`=1). 01 substitutes zero (`sample_zero`=1). 10 passes the sample (both outputs 0). 11 behaves as 00.
- R10: A cycle with `mask_wr_en` high loads `mask_wr_data` into the mask, and the new mask applies to strobes from the next cycle onward. Bit 7 of the written value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_strobe | input | 7 | Error condition strobes, one per class |
| sample_tick | input | 1 | Sample boundary strobe |
| hold_mode | input | 2 | Action on an affected sample |
| mask_wr_en | input | 1 | Mask register write enable |
| mask_wr_data | input | 8 | Mask register write data |
| err_rd | input | 1 | Error register read strobe (clears on read) |
| err_reg | output | 8 | Sticky error register |
| agg_err | output | 1 | Aggregate error |
| err_event | output | 1 | Enabled-error event toward interrupt logic |
| sample_hold | output | 1 | Repeat the current sample |
| sample_zero | output | 1 | Replace the current sample with zero |

## Verification
The assertions assume that the inputs are driven synchronously to `clk` and are free of X once reset is released. They also assume that a set `err_reg` bit can be cleared only by a read, and that a new bit can appear only where a strobe was present. The stimulus drives every input on the falling edge and holds it through the following rising edge. It keeps all strobes low until the internal reset release has completed. The random phase mixes sparse strobe patterns with occasional mask writes, reads and ticks, and covers all four hold-mode codes. This exercises reads and ticks that coincide with new errors while every input stays a defined value.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int unsigned ERR_W  = 7;
  localparam int unsigned REG_W  = 8;
  // classes allowed to alter audio: parity, biphase, confidence, validity, lock loss
  localparam logic [REG_W-1:0] AUDIO_CLASSES = 8'h1F;
  localparam logic [REG_W-1:0] MASK_VALID    = 8'h7F;

  typedef enum logic [1:0] {
    ACT_REPEAT = 2'b00,
    ACT_ZERO   = 2'b01,
    ACT_PASS   = 2'b10,
    ACT_ALT    = 2'b11
  } act_e;
endpackage

// File: rtl/rxerr_rst_sync.sv
module rxerr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rxerr_mask_reg.sv
module rxerr_mask_reg #(
  parameter int unsigned          W     = 8,
  parameter logic [W-1:0]         VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wr_data & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/rxerr_sticky.sv
module rxerr_sticky #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    logic bit_d;

    always_comb begin
      bit_d = (clr_i ? 1'b0 : bit_q) | set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end

    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/rxerr_sample_ctl.sv
module rxerr_sample_ctl
  import rxerr_pkg::*;
#(
  parameter int unsigned  W        = 8,
  parameter logic [W-1:0] AFFECTS  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hits_i,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  output logic         hold_o,
  output logic         zero_o
);
  logic pend_q, pend_d;
  logic hold_q, hold_d;
  logic zero_q, zero_d;
  logic now_hit;
  logic affected;
  act_e mode;

  always_comb begin
    mode     = act_e'(mode_i);
    now_hit  = |(hits_i & AFFECTS);
    affected = pend_q | now_hit;
    pend_d   = pend_q | now_hit;
    hold_d   = hold_q;
    zero_d   = zero_q;
    if (tick_i) begin
      pend_d = 1'b0;
      hold_d = 1'b0;
      zero_d = 1'b0;
      if (affected) begin
        unique case (mode)
          ACT_REPEAT, ACT_ALT: hold_d = 1'b1;
          ACT_ZERO:            zero_d = 1'b1;
          ACT_PASS:            ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      hold_q <= hold_d;
      zero_q <= zero_d;
    end
  end

  assign hold_o = hold_q;
  assign zero_o = zero_q;
endmodule

// File: rtl/rx_error_filter.sv
module rx_error_filter
  import rxerr_pkg::*;
#(
  parameter int unsigned NUM_ERR    = ERR_W,
  parameter int unsigned REG_WIDTH  = REG_W,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_ERR-1:0]   err_strobe,
  input  logic                 sample_tick,
  input  logic [1:0]           hold_mode,
  input  logic                 mask_wr_en,
  input  logic [REG_WIDTH-1:0] mask_wr_data,
  input  logic                 err_rd,
  output logic [REG_WIDTH-1:0] err_reg,
  output logic                 agg_err,
  output logic                 err_event,
  output logic                 sample_hold,
  output logic                 sample_zero
);
  localparam int unsigned PAD_W = REG_WIDTH - NUM_ERR;

  logic                 rst_int_n;
  logic [REG_WIDTH-1:0] mask_q;
  logic [REG_WIDTH-1:0] strobe_pad;
  logic [REG_WIDTH-1:0] hits;
  logic                 event_q, event_d;

  rxerr_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  rxerr_mask_reg #(.W(REG_WIDTH), .VALID(MASK_VALID)) u_mask (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask_o  (mask_q)
  );

  always_comb begin
    strobe_pad = {{PAD_W{1'b0}}, err_strobe};
    hits       = strobe_pad & mask_q;
    event_d    = |hits;
  end

  rxerr_sticky #(.W(REG_WIDTH)) u_sticky (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (hits),
    .clr_i (err_rd),
    .q_o   (err_reg)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) event_q <= 1'b0;
    else            event_q <= event_d;
  end

  rxerr_sample_ctl #(.W(REG_WIDTH), .AFFECTS(AUDIO_CLASSES)) u_sample (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hits_i (hits),
    .tick_i (sample_tick),
    .mode_i (hold_mode),
    .hold_o (sample_hold),
    .zero_o (sample_zero)
  );

  assign agg_err   = |err_reg;
  assign err_event = event_q;
endmodule

// File: rtl/rxerr_filter_chk.sv
module rxerr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] err_strobe,
  input logic       sample_tick,
  input logic [1:0] hold_mode,
  input logic       err_rd,
  input logic [7:0] err_reg,
  input logic       agg_err,
  input logic       err_event,
  input logic       sample_hold,
  input logic       sample_zero
);
  AST_BIT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_reg & ~$past(err_reg) & ~$past({1'b0, err_strobe})) == 8'h00)); // R2

  AST_STICKY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !err_rd |=> ((err_reg & $past(err_reg)) == $past(err_reg))); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && err_strobe == 7'h00) |=> (err_reg == 8'h00)); // R4

  AST_AGG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reg == 8'h00) |-> !agg_err); // R5

  AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!err_event || $past(err_strobe) != 7'h00)); // R6

  AST_ACTION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> ($stable(sample_hold) && $stable(sample_zero))); // R7

  AST_ACTION_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_hold, sample_zero})); // R9

  AST_PASS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && hold_mode == 2'b10) |=> (!sample_hold && !sample_zero)); // R9
endmodule

bind rx_error_filter rxerr_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_strobe  (err_strobe),
  .sample_tick (sample_tick),
  .hold_mode   (hold_mode),
  .err_rd      (err_rd),
  .err_reg     (err_reg),
  .agg_err     (agg_err),
  .err_event   (err_event),
  .sample_hold (sample_hold),
  .sample_zero (sample_zero)
);

// File: tb/rx_error_filter_tb.sv
`timescale 1ns/1ps
module rx_error_filter_tb;
  logic       clk;
  logic       rst_n;
  logic [6:0] err_strobe;
  logic       sample_tick;
  logic [1:0] hold_mode;
  logic       mask_wr_en;
  logic [7:0] mask_wr_data;
  logic       err_rd;
  logic [7:0] err_reg;
  logic       agg_err;
  logic       err_event;
  logic       sample_hold;
  logic       sample_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [7:0] m_mask, m_err;
  logic       m_pend, m_hold, m_zero, m_event;

  rx_error_filter u_dut (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .sample_tick(sample_tick),
    .hold_mode(hold_mode), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .err_rd(err_rd), .err_reg(err_reg), .agg_err(agg_err), .err_event(err_event),
    .sample_hold(sample_hold), .sample_zero(sample_zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(err_reg === m_err, tag, "err_reg", err_reg, m_err);
    check(agg_err === (m_err != 8'h00), tag, "agg_err (R5)", {7'b0, agg_err}, {7'b0, m_err != 8'h00});
    check(err_event === m_event, tag, "err_event (R6)", {7'b0, err_event}, {7'b0, m_event});
    check(sample_hold === m_hold, tag, "sample_hold", {7'b0, sample_hold}, {7'b0, m_hold});
    check(sample_zero === m_zero, tag, "sample_zero", {7'b0, sample_zero}, {7'b0, m_zero});
  endtask

  function automatic void model_step(input logic [6:0] strb, input bit mwe, input logic [7:0] mwd,
                                     input bit rd, input bit tick, input logic [1:0] mode);
    logic [7:0] hits;
    logic       cur;
    hits    = {1'b0, strb} & m_mask;
    m_event = (hits != 8'h00);
    m_err   = (rd ? 8'h00 : m_err) | hits;
    cur     = (hits & 8'h1F) != 8'h00;
    if (tick) begin
      m_hold = (m_pend | cur) && (mode == 2'b00 || mode == 2'b11);
      m_zero = (m_pend | cur) && (mode == 2'b01);
      m_pend = 1'b0;
    end else begin
      m_pend = m_pend | cur;
    end
    if (mwe) m_mask = mwd & 8'h7F;
  endfunction

  task automatic step(input logic [6:0] strb, input bit mwe, input logic [7:0] mwd,
                      input bit rd, input bit tick, input logic [1:0] mode, input string tag);
    err_strobe   = strb;
    mask_wr_en   = mwe;
    mask_wr_data = mwd;
    err_rd       = rd;
    sample_tick  = tick;
    hold_mode    = mode;
    model_step(strb, mwe, mwd, rd, tick, mode);
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    rst_n = 1'b0; err_strobe = '0; sample_tick = 0; hold_mode = 0;
    mask_wr_en = 0; mask_wr_data = 0; err_rd = 0;
    m_mask = 0; m_err = 0; m_pend = 0; m_hold = 0; m_zero = 0; m_event = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R1 after reset");

    // R3 / R1: mask is 00h after reset, every class suppressed
    step(7'h7F, 0, 8'h00, 0, 0, 2'b00, "R3 masked strobe");
    step(7'h1F, 0, 8'h00, 0, 1, 2'b00, "R3 masked tick");
    // R10: bit 7 of the write ignored, new mask applies next cycle
    step(7'h7F, 1, 8'hFF, 0, 0, 2'b00, "R10 write cycle");
    step(7'h7F, 0, 8'h00, 0, 0, 2'b00, "R10 R2 all enabled");
    check(err_reg === 8'h7F, "R2", "bit7 reads 0", err_reg, 8'h7F);
    // R4: read clears, coincident error survives
    step(7'h01, 0, 8'h00, 1, 0, 2'b00, "R4 read with new error");
    check(err_reg === 8'h01, "R4", "coincident bit kept", err_reg, 8'h01);
    step(7'h00, 0, 8'h00, 1, 0, 2'b00, "R4 plain read");
    check(err_reg === 8'h00, "R4", "cleared", err_reg, 8'h00);
    // R7: tick consumes the pending decision (pending from earlier strobes)
    step(7'h00, 0, 8'h00, 0, 1, 2'b00, "R7 tick after errors");
    check(sample_hold === 1'b1, "R7", "hold from earlier errors", {7'b0, sample_hold}, 8'h01);
    step(7'h00, 0, 8'h00, 0, 1, 2'b00, "R7 clean tick");
    check(sample_hold === 1'b0, "R7", "clean sample", {7'b0, sample_hold}, 8'h00);
    // R8: CRC classes enabled but never touch audio
    step(7'h00, 1, 8'h60, 0, 0, 2'b00, "R8 mask crc only");
    step(7'h60, 0, 8'h00, 0, 0, 2'b00, "R8 crc strobes");
    step(7'h60, 0, 8'h00, 0, 1, 2'b00, "R8 crc tick");
    check(!sample_hold && !sample_zero && agg_err, "R8", "crc no audio", {6'b0, sample_hold, sample_zero}, 8'h00);
    // R9: every mode code
    step(7'h00, 1, 8'h7F, 1, 0, 2'b00, "R9 setup");
    step(7'h04, 0, 8'h00, 0, 1, 2'b01, "R9 zero mode");
    check(sample_zero === 1'b1, "R9", "mode 01 zero", {7'b0, sample_zero}, 8'h01);
    step(7'h08, 0, 8'h00, 0, 1, 2'b11, "R9 alt mode");
    check(sample_hold === 1'b1, "R9", "mode 11 repeat", {7'b0, sample_hold}, 8'h01);
    step(7'h10, 0, 8'h00, 0, 1, 2'b10, "R9 pass mode");
    check(!sample_hold && !sample_zero, "R9", "mode 10 pass", {6'b0, sample_hold, sample_zero}, 8'h00);
    step(7'h02, 0, 8'h00, 0, 1, 2'b00, "R9 repeat mode");

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] s;
      s = 7'($urandom) & 7'($urandom) & 7'($urandom);
      step(s, ($urandom % 20) == 0, 8'($urandom), ($urandom % 8) == 0,
           ($urandom % 6) == 0, 2'($urandom), "random R2/R3/R4/R5/R6/R7/R8/R9/R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule